// File: doc/BRIEF.md
# Converter serial readout port with mode capture

This block is the digital output side of a 16-bit sampling converter. It watches three host pins: a convert strobe, a serial clock and a serial data input. It also takes a completion strobe and the finished result word from the converter core. It drives a serial data output and a separate enable that marks when the output is actually driven. When the enable is low, the pin is treated as high impedance.

Each rising edge of the convert strobe starts a new sample. On that edge the port captures its operating style from the pin levels:

- **Select mode.** The host reads the word under a low-active enable. The enable is either the convert strobe or the serial data input.
- **Chain mode.** Several ports are cascaded. Each one shifts its word toward the host and pulls in the word of its upstream neighbour.

In either mode the port can start the readback with a ready indication ahead of the data bits.

The host pins are asynchronous to the system clock. The port brings them in through two-flop synchronisers and finds their edges in the system clock domain. Every edge therefore takes effect a fixed few system cycles after it happens on the pin.

Top module: `adc_sport`

## Requirements
- R1: At a convert-strobe rising edge, a high serial-input level selects select mode and a low level selects chain mode.
- R2: In chain mode, the serial-clock level at the convert-strobe rising edge enables the ready indication when high and disables it when low.
- R3: From a convert-strobe rising edge until the completion strobe, the output enable is low in both modes.
- R4: In select mode, if the convert strobe or the serial input is low when the completion strobe arrives, the output is driven low as a ready indication.
- R5: In select mode without ready indication, the output stays undriven until the enable goes low. It then presents the most significant bit, and each later serial-clock falling edge presents the next bit.
- R6: In select mode, the output enable drops after the 16th falling edge, or the 17th with ready indication, or as soon as both the convert strobe and the serial input are high after the readback started, whichever comes first.
- R7: In chain mode, the most significant bit is driven as soon as the conversion completes. Each serial-clock falling edge shifts the serial input into the word, so a serial-input bit appears at the output 16 falling edges later.
- R8: In chain mode with ready indication, the output follows the serial input after completion until the first falling edge. That first edge presents the most significant bit without shifting.
- R9: While no conversion or readback is active, the output is driven low whenever the convert strobe and the serial input are both low, and is undriven otherwise.
- R10: The result word is two's complement and is sent unchanged with the sign bit first.
- R11: A completion strobe that arrives while no conversion is in progress has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_i | input | 1 | Convert strobe from the host, asynchronous |
| sck_i | input | 1 | Serial clock from the host, asynchronous |
| sdi_i | input | 1 | Serial data input: mode select, enable, or upstream chain data |
| done_i | input | 1 | One-cycle completion strobe from the converter core |
| result_i | input | 16 | Two's complement result, sampled on the completion strobe |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe_o | output | 1 | Output drive enable; low stands for high impedance |

## Verification
A wrongly captured mode or ready flag shows at the first check after completion. The output is either driven when it should float, or it shows the most significant bit where a ready low or the upstream level belongs. A miscounted bit counter or a missed shift corrupts a bit within the next falling edge, or moves the release of the output enable by one edge. A lost chain bit surfaces 16 falling edges after it entered. Each transfer is compared bit by bit against the shift order expected from the word and, in chain mode, from the upstream pattern.

// File: rtl/adc_sport.sv
module adc_sport #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnv_i,
  input  logic          sck_i,
  input  logic          sdi_i,
  input  logic          done_i,
  input  logic [DW-1:0] result_i,
  output logic          sdo_o,
  output logic          sdo_oe_o
);
  localparam int CW = $clog2(DW + 2);

  typedef enum logic [1:0] {PH_IDLE, PH_CONV, PH_READ} phase_t;

  logic [2:0] cnv_q, sck_q;
  logic [1:0] sdi_q;
  phase_t     phase;
  logic       chain, busy, lead, started;
  logic [DW-1:0] sr;
  logic [CW-1:0] cnt, last_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnv_q <= '0;
      sck_q <= '0;
      sdi_q <= '1;
    end else begin
      cnv_q <= {cnv_q[1:0], cnv_i};
      sck_q <= {sck_q[1:0], sck_i};
      sdi_q <= {sdi_q[0], sdi_i};
    end

  wire c_s = cnv_q[1];
  wire k_s = sck_q[1];
  wire d_s = sdi_q[1];
  wire cnv_rise = c_s & ~cnv_q[2];
  wire cnv_fall = ~c_s & cnv_q[2];
  wire sck_fall = ~k_s & sck_q[2];
  wire en = ~c_s | ~d_s;

  assign last_cnt = busy ? CW'(DW + 1) : CW'(DW);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase   <= PH_IDLE;
      chain   <= 1'b0;
      busy    <= 1'b0;
      lead    <= 1'b0;
      started <= 1'b0;
      sr      <= '0;
      cnt     <= '0;
    end else if (cnv_rise) begin
      phase   <= PH_CONV;
      chain   <= ~d_s;
      busy    <= ~d_s & k_s;
      lead    <= 1'b0;
      started <= 1'b0;
      cnt     <= '0;
    end else begin
      unique case (phase)
        PH_CONV: if (done_i) begin
          phase <= PH_READ;
          sr    <= result_i;
          cnt   <= '0;
          if (chain) lead <= busy;
          else begin
            busy    <= en;
            lead    <= en;
            started <= en;
          end
        end
        PH_READ: if (chain) begin
          if (cnv_fall) phase <= PH_IDLE;
          else if (sck_fall) begin
            if (lead) lead <= 1'b0;
            else sr <= {sr[DW-2:0], d_s};
          end
        end else if (started && !en) begin
          phase <= PH_IDLE;
        end else begin
          started <= started | en;
          if (en && sck_fall) begin
            cnt <= cnt + CW'(1);
            if (lead) lead <= 1'b0;
            else sr <= {sr[DW-2:0], 1'b0};
            if (cnt + CW'(1) == last_cnt) phase <= PH_IDLE;
          end
        end
        default: ;
      endcase
    end

  always_comb begin
    sdo_oe_o = 1'b0;
    sdo_o    = 1'b0;
    unique case (phase)
      PH_IDLE: sdo_oe_o = ~c_s & ~d_s;
      PH_READ: if (chain) begin
        sdo_oe_o = 1'b1;
        sdo_o    = lead ? d_s : sr[DW-1];
      end else begin
        sdo_oe_o = en;
        sdo_o    = lead ? 1'b0 : sr[DW-1];
      end
      default: ;
    endcase
  end

  assert_cnv_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_rise |=> !sdo_oe_o);

  assert_busy_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CONV && !cnv_rise && done_i && !chain && en) |=> ((sdo_oe_o && !sdo_o) || !en));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_READ && !chain && started && !en && !cnv_rise) |=> (!sdo_oe_o || en));

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DW + 1));

  assert_chain_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_READ && chain && !lead && sck_fall && !cnv_fall && !cnv_rise)
      |=> (sdo_o == $past(sr[DW-2])));
endmodule

// File: tb/adc_sport_tb.sv
module adc_sport_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cnv = 1'b0, sck = 1'b0, sdi = 1'b1, done = 1'b0;
  logic [15:0] res = '0;
  logic sdo, oe;
  int vectors = 0, miscompares = 0, cyc = 0;

  always #2.5 clk = ~clk;

  adc_sport #(.DW(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sck_i(sck), .sdi_i(sdi),
    .done_i(done), .result_i(res), .sdo_o(sdo), .sdo_oe_o(oe));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic eoe, input logic esdo);
    vectors++;
    if (oe !== eoe || (eoe && sdo !== esdo)) begin
      miscompares++;
      $display("FAIL %s: actual oe=%b sdo=%b, expected oe=%b sdo=%b", tag, oe, sdo, eoe, esdo);
    end
  endtask

  task automatic pulse_done(input logic [15:0] w);
    res = w; done = 1'b1; wait_clk(1); done = 1'b0; wait_clk(5);
  endtask

  task automatic fall_edge();
    sck = 1'b1; wait_clk(4); sck = 1'b0; wait_clk(5);
  endtask

  // stop: falling-edge count after which the enable is deasserted early (4-wire only), 0 = never
  task automatic xfer_cs(input bit bsy, input bit four, input logic [15:0] w, input int stop);
    cnv = 1'b0; sdi = 1'b1; sck = 1'b0; wait_clk(5);
    cnv = 1'b1; wait_clk(5);
    chk("R3 select", 1'b0, 1'b0);
    if (bsy) begin
      if (four) sdi = 1'b0; else cnv = 1'b0;
      wait_clk(5);
    end
    pulse_done(w);
    if (bsy) chk("R4", 1'b1, 1'b0);
    else begin
      chk("R1 select undriven", 1'b0, 1'b0);
      if (four) sdi = 1'b0; else cnv = 1'b0;
      wait_clk(5);
      chk("R5 msb R10", 1'b1, w[15]);
    end
    for (int k = 1; k <= (bsy ? 17 : 16); k++) begin
      int e;
      fall_edge();
      e = bsy ? k - 1 : k;
      if (e < 16) chk(bsy ? "R4 data" : "R5", 1'b1, w[15-e]);
      else chk("R6 count", 1'b0, 1'b0);
      if (stop == k) begin
        sdi = 1'b1; wait_clk(5);
        chk("R6 early", 1'b0, 1'b0);
        return;
      end
    end
  endtask

  task automatic xfer_chain(input bit bsy, input logic [15:0] w, input logic [15:0] u);
    int off;
    off = bsy ? 1 : 0;
    cnv = 1'b0; sdi = 1'b0; sck = bsy; wait_clk(5);
    chk("R9 idle low", 1'b1, 1'b0);
    cnv = 1'b1; wait_clk(5);
    chk("R3 chain", 1'b0, 1'b0);
    sck = 1'b0; wait_clk(5);
    pulse_done(w);
    if (bsy) begin
      chk("R8 sdi low", 1'b1, 1'b0);
      sdi = 1'b1; wait_clk(5);
      chk("R8 sdi high", 1'b1, 1'b1);
    end else chk("R2 R7 msb", 1'b1, w[15]);
    for (int k = 1; k <= 31 + off; k++) begin
      int s;
      if (k > off) sdi = u[15-(k-off-1 > 15 ? 15 : k-off-1)];
      fall_edge();
      s = k - off;
      if (s < 16) chk(bsy ? "R8 R7" : "R7", 1'b1, w[15-s]);
      else chk("R7 delay", 1'b1, u[15-(s-16)]);
    end
    cnv = 1'b0; sdi = 1'b0; wait_clk(5);
    chk("R9 after chain", 1'b1, 1'b0);
  endtask

  function automatic logic [15:0] word_at(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8000;
      3: return 16'h7FFF;
      4: return 16'hA5C3;
      5: return 16'h0001;
      default: return 16'(i * 16'd40503 + 16'd12345);
    endcase
  endfunction

  initial begin
    wait_clk(3);
    chk("R9 reset", 1'b0, 1'b0);
    rst_n = 1'b1; wait_clk(5);
    chk("R9 idle undriven", 1'b0, 1'b0);
    pulse_done(16'hFFFF);
    chk("R11 stray done", 1'b0, 1'b0);
    sdi = 1'b0; wait_clk(5);
    chk("R11 R9 low", 1'b1, 1'b0);
    for (int i = 0; i < 12; i++) begin
      logic [15:0] w;
      w = word_at(i);
      xfer_cs(1'b0, 1'b0, w, 0);
      xfer_cs(1'b1, 1'b0, w, 0);
      xfer_cs(1'b0, 1'b1, w, 0);
      xfer_cs(1'b1, 1'b1, w, 0);
      xfer_chain(1'b0, w, ~w);
      xfer_chain(1'b1, w, w ^ 16'h3C3C);
    end
    xfer_cs(1'b0, 1'b1, 16'hC3A5, 5);
    xfer_cs(1'b1, 1'b1, 16'h5AA5, 7);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule